// File: doc/BRIEF.md
# Character LCD Refresh Controller

This block owns a two-row, sixteen-column text panel wired to a parallel 8-bit write-only bus: register select, enable strobe and eight data lines. After reset it waits for the panel to power up. It then sends a fixed set of set-up commands once, and from then on copies its internal character store to the panel again and again on a fixed period. Software never sends a command. It writes bytes into a 32-entry character store over a single-cycle write port, and the next refresh shows them.

Each byte on the panel bus is sent the same way. Register select and data are set up first. A fixed-width enable pulse follows, and then a hold-off gap before the next byte. All of these lengths are given in clock cycles as parameters, so one build fits any clock rate. Characters are always written in store order. The block sends the address command for the start of the second row after the sixteenth character on its own, so the store is a plain row-major image of the screen.

Top module: `lcd_text_refresh`

## Requirements
- R1: While reset is held, and for at least POWERUP_CYC cycles after it is released, lcd_en stays low. After reset every store entry holds 0x20 (space), so the first frame shows 32 spaces.
- R2: The first four bytes sent after reset are commands with lcd_rs low, in this order: 0x38 (8-bit bus, two rows), 0x0C (display on, cursor off), 0x01 (clear), 0x06 (increment entry).
- R3: Between the end of the enable pulse of the clear command (0x01) and the next enable rise there are at least CLEAR_GAP_CYC + SETUP_CYC cycles.
- R4: Every enable pulse is high for exactly E_HIGH_CYC cycles. lcd_rs and lcd_data stay steady for at least SETUP_CYC cycles before the rise and for the whole high time.
- R5: Between any enable fall and the next rise there are at least GAP_CYC + SETUP_CYC cycles.
- R6: Each frame is, in order: command 0x80 (lcd_rs low), store entries 0 to 15 as data (lcd_rs high), command 0xC0 (lcd_rs low), store entries 16 to 31 as data.
- R7: The enable rises of the 0x80 commands that start two frames in a row are exactly REFRESH_CYC cycles apart, and frames repeat without end.
- R8: A cycle with wr_en high stores wr_data at entry wr_addr (entry = row*16 + column) in that cycle, with no wait. The value an entry has when its turn comes in a frame is the value shown, so a write to an entry not yet sent appears in the same frame, and a write to one already sent appears in the next.
- R9: The set-up commands are never sent again after the first frame begins. The only commands sent after that are 0x80 and 0xC0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Character store write strobe |
| wr_addr | input | 5 | Store entry, row*16 + column |
| wr_data | input | 8 | Character code to store |
| lcd_rs | output | 1 | Panel register select: low = command, high = character |
| lcd_en | output | 1 | Panel enable strobe; the byte is taken on its fall |
| lcd_data | output | 8 | Panel data bus |

## Verification
The bench builds the block as a two-row, sixteen-column panel with very short timings. Setup is 1 cycle, the enable pulse 3, the gap 6, the clear gap 20, the power-up wait 10 and the refresh period 500. Thirteen whole frames and every enable edge therefore fit in a few thousand cycles. With this build the bench can compare every byte sent against a computed stream and check each pulse width and gap. It can also write each of the 256 character codes through the store, place a write in the middle of a frame, and measure the refresh period from one frame start to the next.

// File: rtl/lcd_refresh_pkg.sv
package lcd_refresh_pkg;

   typedef enum logic [2:0] {
      SQ_POWER,
      SQ_INIT,
      SQ_LINE,
      SQ_CHAR,
      SQ_WAIT
   } seq_state_e;

   typedef enum logic [1:0] {
      WP_IDLE,
      WP_SETUP,
      WP_PULSE,
      WP_GAP
   } wr_phase_e;

   localparam logic [7:0] CMD_HOME_ADDR = 8'h80;
   localparam logic [7:0] CMD_ROW1_ADDR = 8'hC0;
   localparam logic [7:0] CMD_ON_NOCUR  = 8'h0C;
   localparam logic [7:0] CMD_CLEAR     = 8'h01;
   localparam logic [7:0] CMD_ENTRY_INC = 8'h06;
   localparam logic [7:0] CHAR_BLANK    = 8'h20;
   localparam int         INIT_STEPS    = 4;
   localparam int         CLEAR_STEP    = 2;

   function automatic logic [7:0] func_set_cmd(input int rows);
      return (rows > 1) ? 8'h38 : 8'h30;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lcd_char_buf.sv
module lcd_char_buf
   import lcd_refresh_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];
   logic       addr_ok;

   generate
      if (DEPTH == (1 << AW)) begin : g_full
         assign addr_ok = 1'b1;
      end else begin : g_part
         assign addr_ok = (waddr < AW'(DEPTH));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= CHAR_BLANK;
      end else if (we && addr_ok) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer
   import lcd_refresh_pkg::*;
#(
   parameter int SETUP_CYC    = 2,
   parameter int E_HIGH_CYC   = 25,
   parameter int GAP_CYC      = 2000,
   parameter int LONG_GAP_CYC = 82000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       go_rs,
   input  logic [7:0] go_data,
   input  logic       go_long,
   output logic       done,
   output logic       lcd_rs,
   output logic       lcd_en,
   output logic [7:0] lcd_data
);

   localparam int MAXC = max2(max2(SETUP_CYC, E_HIGH_CYC), max2(GAP_CYC, LONG_GAP_CYC));
   localparam int CW   = $clog2(MAXC + 1);

   wr_phase_e   ph;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic        long_q;
   logic        last;

   always_comb begin
      case (ph)
         WP_SETUP: lim = CW'(SETUP_CYC - 1);
         WP_PULSE: lim = CW'(E_HIGH_CYC - 1);
         WP_GAP:   lim = long_q ? CW'(LONG_GAP_CYC - 1) : CW'(GAP_CYC - 1);
         default:  lim = '0;
      endcase
   end

   assign last = (cnt == lim);
   assign done = (ph == WP_GAP) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= WP_IDLE;
         cnt      <= '0;
         long_q   <= 1'b0;
         lcd_rs   <= 1'b0;
         lcd_data <= '0;
         lcd_en   <= 1'b0;
      end else begin
         lcd_en <= ((ph == WP_SETUP) && last) || ((ph == WP_PULSE) && !last);
         case (ph)
            WP_IDLE: begin
               if (go) begin
                  ph       <= WP_SETUP;
                  cnt      <= '0;
                  long_q   <= go_long;
                  lcd_rs   <= go_rs;
                  lcd_data <= go_data;
               end
            end
            default: begin
               if (last) begin
                  cnt <= '0;
                  case (ph)
                     WP_SETUP: ph <= WP_PULSE;
                     WP_PULSE: ph <= WP_GAP;
                     default:  ph <= WP_IDLE;
                  endcase
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/lcd_refresh_seq.sv
module lcd_refresh_seq
   import lcd_refresh_pkg::*;
#(
   parameter int ROWS        = 2,
   parameter int COLS        = 16,
   parameter int POWERUP_CYC = 750000,
   parameter int REFRESH_CYC = 2500000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          done,
   input  logic [7:0]                    rd_data,
   output logic [$clog2(ROWS*COLS)-1:0]  rd_addr,
   output logic                          go,
   output logic                          go_rs,
   output logic [7:0]                    go_data,
   output logic                          go_long
);

   localparam int NCHAR = ROWS * COLS;
   localparam int AW    = $clog2(NCHAR);
   localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int CLW   = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int TW    = $clog2(max2(POWERUP_CYC, REFRESH_CYC) + 1);
   localparam logic [AW-1:0] COLS_A = AW'(COLS);

   seq_state_e     st;
   logic [1:0]     init_idx;
   logic [RW-1:0]  row;
   logic [CLW-1:0] col;
   logic [TW-1:0]  tmr;
   logic           pending;
   logic [7:0]     init_cmd;
   logic [7:0]     line_cmd;
   logic           emit;

   always_comb begin
      case (init_idx)
         2'd0:    init_cmd = func_set_cmd(ROWS);
         2'd1:    init_cmd = CMD_ON_NOCUR;
         2'd2:    init_cmd = CMD_CLEAR;
         default: init_cmd = CMD_ENTRY_INC;
      endcase
   end

   generate
      if (ROWS == 2) begin : g_two_rows
         assign line_cmd = row[0] ? CMD_ROW1_ADDR : CMD_HOME_ADDR;
      end else begin : g_one_row
         assign line_cmd = CMD_HOME_ADDR;
      end
   endgenerate

   assign rd_addr = AW'(AW'(row) * COLS_A + AW'(col));
   assign emit    = (st == SQ_INIT) || (st == SQ_LINE) || (st == SQ_CHAR);
   assign go      = emit && !pending;

   always_comb begin
      go_rs   = 1'b0;
      go_long = 1'b0;
      go_data = line_cmd;
      case (st)
         SQ_INIT: begin
            go_data = init_cmd;
            go_long = (init_idx == 2'(CLEAR_STEP));
         end
         SQ_CHAR: begin
            go_rs   = 1'b1;
            go_data = rd_data;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_POWER;
         init_idx <= '0;
         row      <= '0;
         col      <= '0;
         tmr      <= '0;
         pending  <= 1'b0;
      end else begin
         if (go) pending <= 1'b1;
         else if (done) pending <= 1'b0;
         case (st)
            SQ_POWER: begin
               if (tmr == TW'(POWERUP_CYC - 1)) begin
                  st  <= SQ_INIT;
                  tmr <= '0;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            SQ_INIT: begin
               if (done) begin
                  if (init_idx == 2'(INIT_STEPS - 1)) begin
                     st  <= SQ_LINE;
                     row <= '0;
                     tmr <= '0;
                  end else begin
                     init_idx <= init_idx + 1'b1;
                  end
               end
            end
            SQ_LINE: begin
               tmr <= tmr + 1'b1;
               if (done) begin
                  st  <= SQ_CHAR;
                  col <= '0;
               end
            end
            SQ_CHAR: begin
               tmr <= tmr + 1'b1;
               if (done) begin
                  if (col == CLW'(COLS - 1)) begin
                     if (row == RW'(ROWS - 1)) begin
                        st <= SQ_WAIT;
                     end else begin
                        row <= row + 1'b1;
                        st  <= SQ_LINE;
                     end
                  end else begin
                     col <= col + 1'b1;
                  end
               end
            end
            default: begin
               if (tmr == TW'(REFRESH_CYC - 1)) begin
                  st  <= SQ_LINE;
                  row <= '0;
                  tmr <= '0;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/lcd_text_refresh.sv
module lcd_text_refresh
   import lcd_refresh_pkg::*;
#(
   parameter int ROWS          = 2,
   parameter int COLS          = 16,
   parameter int SETUP_CYC     = 2,
   parameter int E_HIGH_CYC    = 25,
   parameter int GAP_CYC       = 2000,
   parameter int CLEAR_GAP_CYC = 82000,
   parameter int POWERUP_CYC   = 750000,
   parameter int REFRESH_CYC   = 2500000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(ROWS*COLS)-1:0]  wr_addr,
   input  logic [7:0]                    wr_data,
   output logic                          lcd_rs,
   output logic                          lcd_en,
   output logic [7:0]                    lcd_data
);

   localparam int NCHAR     = ROWS * COLS;
   localparam int AW        = $clog2(NCHAR);
   localparam int BYTE_CYC  = SETUP_CYC + E_HIGH_CYC + GAP_CYC + 1;
   localparam int FRAME_CYC = (NCHAR + ROWS) * BYTE_CYC;

   generate
      if (ROWS < 1 || ROWS > 2) begin : g_bad_rows
         $error("lcd_text_refresh: ROWS must be 1 or 2");
      end
      if (COLS < 2 || COLS > 40) begin : g_bad_cols
         $error("lcd_text_refresh: COLS must be 2 to 40");
      end
      if (SETUP_CYC < 1 || E_HIGH_CYC < 1 || GAP_CYC < 1 || POWERUP_CYC < 1) begin : g_bad_time
         $error("lcd_text_refresh: timing counts must be at least 1");
      end
      if (CLEAR_GAP_CYC < GAP_CYC) begin : g_bad_clear
         $error("lcd_text_refresh: CLEAR_GAP_CYC below GAP_CYC");
      end
      if (REFRESH_CYC <= FRAME_CYC) begin : g_bad_refresh
         $error("lcd_text_refresh: REFRESH_CYC shorter than one frame");
      end
   endgenerate

   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;
   logic          go;
   logic          go_rs;
   logic [7:0]    go_data;
   logic          go_long;
   logic          done;

   lcd_char_buf #(
      .DEPTH (NCHAR),
      .AW    (AW)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   lcd_refresh_seq #(
      .ROWS        (ROWS),
      .COLS        (COLS),
      .POWERUP_CYC (POWERUP_CYC),
      .REFRESH_CYC (REFRESH_CYC)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .go      (go),
      .go_rs   (go_rs),
      .go_data (go_data),
      .go_long (go_long)
   );

   lcd_bus_writer #(
      .SETUP_CYC    (SETUP_CYC),
      .E_HIGH_CYC   (E_HIGH_CYC),
      .GAP_CYC      (GAP_CYC),
      .LONG_GAP_CYC (CLEAR_GAP_CYC)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .go_rs    (go_rs),
      .go_data  (go_data),
      .go_long  (go_long),
      .done     (done),
      .lcd_rs   (lcd_rs),
      .lcd_en   (lcd_en),
      .lcd_data (lcd_data)
   );

endmodule

// File: rtl/lcd_text_refresh_chk.sv
module lcd_text_refresh_chk
   import lcd_refresh_pkg::*;
#(
   parameter int ROWS        = 2,
   parameter int COLS        = 16,
   parameter int SETUP_CYC   = 2,
   parameter int E_HIGH_CYC  = 25,
   parameter int GAP_CYC     = 2000,
   parameter int REFRESH_CYC = 2500000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       lcd_en,
   input logic       lcd_rs,
   input logic [7:0] lcd_data
);

   int unsigned hi_cnt;
   int unsigned lo_cnt;
   int unsigned chr_cnt;
   int unsigned per_cnt;
   logic        en_d;
   logic        seen_pulse;
   logic        seen_home;
   logic        rise;
   logic        home_cmd;

   assign rise     = lcd_en && !en_d;
   assign home_cmd = !lcd_rs && (lcd_data == CMD_HOME_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt     <= 0;
         lo_cnt     <= 0;
         chr_cnt    <= 0;
         per_cnt    <= 0;
         en_d       <= 1'b0;
         seen_pulse <= 1'b0;
         seen_home  <= 1'b0;
      end else begin
         en_d   <= lcd_en;
         hi_cnt <= lcd_en ? hi_cnt + 1 : 0;
         if (lcd_en) lo_cnt <= 0;
         else if (lo_cnt != 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 1;
         if (lcd_en) seen_pulse <= 1'b1;
         if (rise && lcd_rs) chr_cnt <= chr_cnt + 1;
         else if (rise && home_cmd) chr_cnt <= 0;
         if (rise && home_cmd) begin
            per_cnt   <= 1;
            seen_home <= 1'b1;
         end else if (per_cnt != 32'hFFFF_FFFF) begin
            per_cnt <= per_cnt + 1;
         end
      end
   end

   AST_E_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) |-> hi_cnt == E_HIGH_CYC); // R4
   AST_E_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_en && $past(lcd_en) |-> $stable({lcd_rs, lcd_data})); // R4
   AST_E_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> $stable({lcd_rs, lcd_data})); // R4
   AST_BYTE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      rise && seen_pulse |-> lo_cnt >= GAP_CYC + SETUP_CYC); // R5
   AST_FIRST_FUNCSET: assert property (@(posedge clk) disable iff (!rst_n)
      rise && !seen_pulse |-> !lcd_rs && lcd_data == func_set_cmd(ROWS)); // R2
   AST_REFRESH_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      rise && home_cmd && seen_home |-> per_cnt == REFRESH_CYC); // R7

   generate
      if (ROWS == 2) begin : g_jump
         AST_ROW_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
            rise && !lcd_rs && lcd_data == CMD_ROW1_ADDR |-> chr_cnt == COLS); // R6
      end
   endgenerate

endmodule

bind lcd_text_refresh lcd_text_refresh_chk #(
   .ROWS        (ROWS),
   .COLS        (COLS),
   .SETUP_CYC   (SETUP_CYC),
   .E_HIGH_CYC  (E_HIGH_CYC),
   .GAP_CYC     (GAP_CYC),
   .REFRESH_CYC (REFRESH_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lcd_en   (lcd_en),
   .lcd_rs   (lcd_rs),
   .lcd_data (lcd_data)
);

// File: tb/test_lcd_text_refresh.sv
module test_lcd_text_refresh;

   localparam int ROWS    = 2;
   localparam int COLS    = 16;
   localparam int SETUP   = 1;
   localparam int EHI     = 3;
   localparam int GAP     = 6;
   localparam int CLRGAP  = 20;
   localparam int PWR     = 10;
   localparam int REFRESH = 500;
   localparam int AW      = 5;
   localparam int NCH     = 32;
   localparam int EV_INIT = 4;
   localparam int FR_EV   = 34;
   localparam int NF      = 13;
   localparam int NE      = EV_INIT + FR_EV * NF;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;
   logic          lcd_rs;
   logic          lcd_en;
   logic [7:0]    lcd_data;

   always #2 clk = ~clk;

   lcd_text_refresh #(
      .ROWS(ROWS), .COLS(COLS), .SETUP_CYC(SETUP), .E_HIGH_CYC(EHI),
      .GAP_CYC(GAP), .CLEAR_GAP_CYC(CLRGAP), .POWERUP_CYC(PWR), .REFRESH_CYC(REFRESH)
   ) i_lcd_text_refresh (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .lcd_rs(lcd_rs), .lcd_en(lcd_en), .lcd_data(lcd_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int rel_cyc = 0;

   bit         ev_rs   [512];
   logic [7:0] ev_dat  [512];
   int         ev_rise [512];
   int         ev_n = 0;
   logic [7:0] exp_ch  [NF*NCH];

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // panel-side model: watches the write strobe on the falling clock edge
   logic [8:0] prv_bus = '0;
   logic [8:0] hold_bus = '0;
   bit         prv_en = 1'b0;
   bit         hold_bad = 1'b0;
   int         stab = 0;
   int         hi = 0;
   int         lo = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if ({lcd_rs, lcd_data} == prv_bus) stab++;
         else stab = 0;
         prv_bus = {lcd_rs, lcd_data};
         if (lcd_en && !prv_en) begin
            if (ev_n < 512) ev_rise[ev_n] = cyc;
            chk(stab >= SETUP, "R4 setup before enable rise", stab, SETUP);
            if (ev_n == 3)
               chk(lo >= CLRGAP + SETUP, "R3 wait after clear", lo, CLRGAP + SETUP);
            else if (ev_n > 0)
               chk(lo >= GAP + SETUP, "R5 gap between bytes", lo, GAP + SETUP);
            hold_bus = {lcd_rs, lcd_data};
            hold_bad = 1'b0;
            hi = 1;
         end else if (lcd_en) begin
            hi++;
            if ({lcd_rs, lcd_data} != hold_bus) hold_bad = 1'b1;
         end else if (prv_en) begin
            chk(hi == EHI, "R4 enable high width", hi, EHI);
            chk(!hold_bad, "R4 bus steady while enable high", hold_bad, 0);
            if (ev_n < 512) begin
               ev_rs[ev_n]  = hold_bus[8];
               ev_dat[ev_n] = hold_bus[7:0];
            end
            ev_n++;
            lo = 1;
         end else begin
            lo++;
         end
         prv_en = lcd_en;
      end
   end

   task automatic wait_ev(input int n);
      while (ev_n < n) @(negedge clk);
   endtask

   task automatic put(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = d;
   endtask

   task automatic put_end();
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      chk(1'b0, "watchdog expired", ev_n, NE);
      summary();
      $finish;
   end

   initial begin
      bit         ers;
      logic [7:0] ed;
      string      tag;
      int         bad_cmd;
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      for (int i = 0; i < NCH; i++) exp_ch[i] = 8'h20;
      repeat (5) begin
         @(negedge clk);
         chk(lcd_en == 1'b0, "R1 enable low in reset", lcd_en, 0);
      end
      rst_n   = 1'b1;
      rel_cyc = cyc;

      // frame 1: ascending letters
      wait_ev(EV_INIT + FR_EV * 1);
      for (int i = 0; i < NCH; i++) begin
         put(i, 8'(8'h41 + i));
         exp_ch[1*NCH + i] = 8'(8'h41 + i);
      end
      put_end();

      // frames 2 and 3: second pattern, with a mid-frame write during frame 3
      wait_ev(EV_INIT + FR_EV * 2);
      for (int i = 0; i < NCH; i++) begin
         put(i, 8'(i * 7 + 3));
         exp_ch[2*NCH + i] = 8'(i * 7 + 3);
         exp_ch[3*NCH + i] = 8'(i * 7 + 3);
         exp_ch[4*NCH + i] = 8'(i * 7 + 3);
      end
      put_end();
      wait_ev(EV_INIT + FR_EV * 3 + 6);
      put(0, 8'hEE);
      put(31, 8'hDD);
      put_end();
      exp_ch[3*NCH + 31] = 8'hDD;
      exp_ch[4*NCH + 0]  = 8'hEE;
      exp_ch[4*NCH + 31] = 8'hDD;

      // frames 5..12: every character code once
      for (int f = 5; f < NF; f++) begin
         wait_ev(EV_INIT + FR_EV * f);
         for (int i = 0; i < NCH; i++) begin
            put(i, 8'((f - 5) * NCH + i));
            exp_ch[f*NCH + i] = 8'((f - 5) * NCH + i);
         end
         put_end();
      end

      wait_ev(NE);

      chk(ev_rise[0] - rel_cyc >= PWR, "R1 quiet power-up wait", ev_rise[0] - rel_cyc, PWR);

      for (int k = 0; k < NE; k++) begin
         if (k < EV_INIT) begin
            ers = 1'b0;
            tag = "R2 init byte";
            case (k)
               0: ed = 8'h38;
               1: ed = 8'h0C;
               2: ed = 8'h01;
               default: ed = 8'h06;
            endcase
         end else begin
            int f;
            int p;
            f = (k - EV_INIT) / FR_EV;
            p = (k - EV_INIT) % FR_EV;
            if (p == 0) begin
               ers = 1'b0; ed = 8'h80; tag = "R6 row 0 address";
            end else if (p == 17) begin
               ers = 1'b0; ed = 8'hC0; tag = "R6 row 1 address";
            end else begin
               ers = 1'b1;
               ed  = (p < 17) ? exp_ch[f*NCH + p - 1] : exp_ch[f*NCH + 16 + p - 18];
               tag = (f == 0) ? "R1 blank store" : "R8 character";
            end
         end
         chk(ev_rs[k] == ers && ev_dat[k] == ed, tag, {ev_rs[k], ev_dat[k]}, {ers, ed});
      end

      for (int f = 1; f < NF; f++)
         chk(ev_rise[EV_INIT + FR_EV*f] - ev_rise[EV_INIT + FR_EV*(f-1)] == REFRESH,
             "R7 refresh period",
             ev_rise[EV_INIT + FR_EV*f] - ev_rise[EV_INIT + FR_EV*(f-1)], REFRESH);

      bad_cmd = 0;
      for (int k = EV_INIT; k < NE; k++)
         if (!ev_rs[k] && ev_dat[k] != 8'h80 && ev_dat[k] != 8'hC0) bad_cmd++;
      chk(bad_cmd == 0, "R9 set-up commands not repeated", bad_cmd, 0);

      summary();
      $finish;
   end

endmodule